// File: doc/BRIEF.md
# NAND Controller Register Bank with Write Lock

This block is the control and status register file of a NAND flash controller. Software reaches it through a plain 32-bit register port with a byte address, a write strobe, per-byte enables, a read strobe and read data that is valid while the read strobe is high. The block holds the interface setup, the strobe timing, the interrupt enable mask, a latched interrupt status, a live status view, the chip-enable mode and a command register. Each of these drives its fields straight to the rest of the controller.

The interface setup and strobe timing are guarded. A write to either one is taken only when a magic key written to the lock register has just opened them. Any such write closes them again. If a guarded write arrives while the registers are closed, the write is dropped and a sticky violation bit is set.

One-cycle event pulses from the controller's datapath set bits in the latched status. Reading that status returns the bits and clears them in the same access. A single active-high level interrupt reports any latched bit that is also enabled in the mask.

Top module: `nand_regbank`

## Requirements
- R1: After reset, every register reads zero except chip-enable mode (offset 0x14), which reads 1. The block is locked and `irq` is low. Only word-aligned addresses below 0x20 are decoded. Any other address is ignored and reads zero.
- R2: Writing 0xA25E to bits 15:0 of the lock register (offset 0x1C), with byte enables 0 and 1 both set, opens the guarded registers: interface setup at 0x00 and timing at 0x04. A write of any other value to the lock register closes them. A write to a guarded register while it is open is merged byte by byte under the byte enables.
- R3: One write to either guarded register closes the lock again. A second write without a new key is ignored.
- R4: A write to a guarded register while the lock is closed leaves its outputs unchanged. It also sets a sticky violation flag, which reads as bit 7 of the live status register at 0x10.
- R5: The interface setup bits drive outputs. Bit 3 is write-protect enable, bit 2 is large-block mode, bit 1 is long addressing and bit 0 is 16-bit bus.
- R6: The timing register fields drive outputs. Bits 25:24 are the chip-enable-to-access delay, 23:19 busy delay, 18:16 turnaround, 15:12 read-high, 11:8 read-low, 7:4 write-high and 3:0 write-low.
- R7: A pulse on `evt_pulse[i]` sets bit i of the latched status at 0x0C. The bit stays set until it is read. The bit map is: 5 NAND ready, 4 controller ready, 3 decode failure, 2 decode error, 1 ECC ready, 0 write-protect fault.
- R8: A read of 0x0C returns the latched bits and clears them. If an event pulse arrives in the same cycle as the read, that bit stays set.
- R9: `irq` is high while any latched status bit is set and its enable bit is set in the mask at 0x08. The mask uses the same bit map as the status.
- R10: Writing 0xFF to bits 7:0 of the command register (offset 0x18) returns every register to its R1 value and closes the lock. Any other command value has no effect.
- R11: Bit 0 of chip-enable mode drives `ce_normal`. A value of 1 means the controller drives chip enable; 0 forces chip enable active.
- R12: Bits 6:0 of the live status register show `st_live` as it is in that cycle. In order from bit 6 down, they are decoder failure, corrected count minus one (bits 5:4), errors detected, ECC ready, controller ready and NAND ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| evt_pulse | input | 6 | One-cycle event pulses |
| st_live | input | 7 | Live controller status |
| irq | output | 1 | Level interrupt |
| cfg_wp_en | output | 1 | Write-protect enable |
| cfg_large_blk | output | 1 | Large-block page mode |
| cfg_long_addr | output | 1 | Five-byte addressing |
| cfg_bus16 | output | 1 | 16-bit bus |
| tim_ce_dly | output | 2 | Chip-enable-to-access delay |
| tim_busy | output | 5 | Busy delay |
| tim_ta | output | 3 | Turnaround |
| tim_rd_hi | output | 4 | Read-high time |
| tim_rd_lo | output | 4 | Read-low time |
| tim_wr_hi | output | 4 | Write-high time |
| tim_wr_lo | output | 4 | Write-low time |
| ce_normal | output | 1 | Chip-enable mode |

## Verification
A lock state that stays open shows up on the very next guarded write: the setup or timing outputs change when they should not, and the violation bit stays clear. A lock state that stays closed drops a keyed write, so the outputs keep their old values one cycle later. A status bit that clears wrongly, or fails to clear, shows in the next read of 0x0C and on `irq` one cycle after the read. The bench therefore reads back after every guarded write and after every event/read overlap.

// File: rtl/nrb_pkg.sv
// Shared types and constants for the NAND register bank.
// Assumes a 32-bit data path with four byte enables.
package nrb_pkg;
    localparam int DW     = 32;
    localparam int BE_W   = DW / 8;
    localparam int NEVT   = 6;
    localparam int NLIVE  = 7;
    localparam int TIM_W  = 26;
    localparam logic [15:0] KEY     = 16'hA25E;
    localparam logic [7:0]  CMD_RST = 8'hFF;

    typedef enum logic [2:0] {
        R_CFG   = 3'd0,
        R_TIM   = 3'd1,
        R_MASK  = 3'd2,
        R_STAT  = 3'd3,
        R_LIVE  = 3'd4,
        R_CEM   = 3'd5,
        R_CMD   = 3'd6,
        R_LOCK  = 3'd7
    } reg_idx_e;

    // Merge new data into old data under byte enables
    function automatic logic [DW-1:0] byte_merge(logic [DW-1:0] old_v,
                                                 logic [DW-1:0] new_v,
                                                 logic [BE_W-1:0] be);
        logic [DW-1:0] r;
        for (int b = 0; b < BE_W; b++)
            r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        return r;
    endfunction
endpackage

// File: rtl/nrb_lock.sv
// Key lock for the guarded registers.
// Opens on a key write, closes after one guarded write or on any other
// lock value, and flags guarded writes that arrive while closed.
// Assumes lock_wr and prot_wr are never high together (one bus access).
module nrb_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic lock_wr,
    input  logic key_hit,
    input  logic prot_wr,
    output logic unlocked,
    output logic prot_ok,
    output logic viol
);
    assign prot_ok = prot_wr && unlocked;

    // Lock state and sticky violation flag
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            unlocked <= 1'b0;
            viol     <= 1'b0;
        end else if (prot_wr) begin
            unlocked <= 1'b0;
            if (!unlocked)
                viol <= 1'b1;
        end else if (lock_wr) begin
            unlocked <= key_hit;
        end
    end
endmodule

// File: rtl/nrb_irq.sv
// Latched interrupt status with clear-on-read and a level interrupt.
// Assumes events are one-cycle pulses. An event beats a clearing read
// in the same cycle.
module nrb_irq #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [N-1:0] evt,
    input  logic         rd_clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] stat,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One sticky bit: set by event, cleared by read
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst)
                stat[i] <= 1'b0;
            else if (evt[i])
                stat[i] <= 1'b1;
            else if (rd_clr)
                stat[i] <= 1'b0;
        end
    end

    assign irq = |(stat & mask);
endmodule

// File: rtl/nand_regbank.sv
// Register bank of a NAND flash controller.
// Decodes word-aligned byte addresses below 0x20. Read data is
// combinational while bus_rd is high. The setup and timing registers
// are guarded by nrb_lock.
module nand_regbank
    import nrb_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic [5:0]        evt_pulse,
    input  logic [6:0]        st_live,
    output logic              irq,
    output logic              cfg_wp_en,
    output logic              cfg_large_blk,
    output logic              cfg_long_addr,
    output logic              cfg_bus16,
    output logic [1:0]        tim_ce_dly,
    output logic [4:0]        tim_busy,
    output logic [2:0]        tim_ta,
    output logic [3:0]        tim_rd_hi,
    output logic [3:0]        tim_rd_lo,
    output logic [3:0]        tim_wr_hi,
    output logic [3:0]        tim_wr_lo,
    output logic              ce_normal
);
    localparam int IDX_LSB = 2;
    localparam int IDX_W   = 3;
    localparam int SPAN    = IDX_LSB + IDX_W;

    reg_idx_e          idx;
    logic              sel_ok, wr_any, rd_any;
    logic              soft_rst, prot_wr, prot_ok, unlocked, viol;
    logic [3:0]        cfg_q;
    logic [TIM_W-1:0]  tim_q;
    logic [NEVT-1:0]   mask_q, ist_q;
    logic              cem_q;
    logic [DW-1:0]     cfg_nxt, tim_nxt, mask_nxt, cem_nxt;
    logic [DW-1:0]     rd_mux;

    assign idx    = reg_idx_e'(bus_addr[SPAN-1:IDX_LSB]);
    assign sel_ok = (bus_addr[IDX_LSB-1:0] == '0) && ((bus_addr >> SPAN) == '0);
    assign wr_any = bus_wr && sel_ok;
    assign rd_any = bus_rd && sel_ok;

    assign soft_rst = wr_any && idx == R_CMD && bus_be[0] && bus_wdata[7:0] == CMD_RST;
    assign prot_wr  = wr_any && (idx == R_CFG || idx == R_TIM);

    nrb_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .lock_wr  (wr_any && idx == R_LOCK),
        .key_hit  (bus_be[1:0] == 2'b11 && bus_wdata[15:0] == KEY),
        .prot_wr  (prot_wr),
        .unlocked (unlocked),
        .prot_ok  (prot_ok),
        .viol     (viol)
    );

    nrb_irq #(.N(NEVT)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .evt      (evt_pulse),
        .rd_clr   (rd_any && idx == R_STAT),
        .mask     (mask_q),
        .stat     (ist_q),
        .irq      (irq)
    );

    assign cfg_nxt  = byte_merge({28'b0, cfg_q}, bus_wdata, bus_be);
    assign tim_nxt  = byte_merge({{(DW-TIM_W){1'b0}}, tim_q}, bus_wdata, bus_be);
    assign mask_nxt = byte_merge({{(DW-NEVT){1'b0}}, mask_q}, bus_wdata, bus_be);
    assign cem_nxt  = byte_merge({31'b0, cem_q}, bus_wdata, bus_be);

    // Guarded setup and timing registers
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cfg_q <= '0;
            tim_q <= '0;
        end else if (prot_ok) begin
            if (idx == R_CFG) cfg_q <= cfg_nxt[3:0];
            else              tim_q <= tim_nxt[TIM_W-1:0];
        end
    end

    // Open registers: interrupt mask and chip-enable mode
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            mask_q <= '0;
            cem_q  <= 1'b1;
        end else if (wr_any && idx == R_MASK) begin
            mask_q <= mask_nxt[NEVT-1:0];
        end else if (wr_any && idx == R_CEM) begin
            cem_q  <= cem_nxt[0];
        end
    end

    // Read-data multiplexer
    always_comb begin
        rd_mux = '0;
        case (idx)
            R_CFG:   rd_mux = {28'b0, cfg_q};
            R_TIM:   rd_mux = {{(DW-TIM_W){1'b0}}, tim_q};
            R_MASK:  rd_mux = {{(DW-NEVT){1'b0}}, mask_q};
            R_STAT:  rd_mux = {{(DW-NEVT){1'b0}}, ist_q};
            R_LIVE:  rd_mux = {24'b0, viol, st_live};
            R_CEM:   rd_mux = {31'b0, cem_q};
            default: rd_mux = '0;
        endcase
    end

    assign bus_rdata = rd_any ? rd_mux : '0;

    assign {cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16} = cfg_q;
    assign {tim_ce_dly, tim_busy, tim_ta, tim_rd_hi, tim_rd_lo, tim_wr_hi, tim_wr_lo} = tim_q;
    assign ce_normal = cem_q;
endmodule

// File: rtl/nrb_checker.sv
// Protocol properties for nand_regbank, attached by bind.
module nrb_checker #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd,
    input logic [5:0]        evt_pulse,
    input logic [3:0]        cfg_vec,
    input logic              unlocked,
    input logic [5:0]        ist,
    input logic [5:0]        imask
);
    logic       ok;
    logic [2:0] ix;
    logic       c_soft;
    assign ok     = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 5) == '0);
    assign ix     = bus_addr[4:2];
    assign c_soft = bus_wr && ok && ix == 3'd6 && bus_be[0] && bus_wdata[7:0] == 8'hFF;

    AST_LOCKED_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ok && ix == 3'd0 && !unlocked) |=> $stable(cfg_vec)); // R4
    AST_RELOCK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ok && (ix == 3'd0 || ix == 3'd1)) |=> !unlocked); // R3
    AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != 0 && !c_soft) |=> ((ist & $past(evt_pulse)) == $past(evt_pulse))); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ok && ix == 3'd3 && evt_pulse == 0) |=> (ist == 0)); // R8
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        c_soft |=> (!unlocked && ist == 0 && imask == 0 && cfg_vec == 0)); // R10
endmodule

bind nand_regbank nrb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .evt_pulse (evt_pulse),
    .cfg_vec   ({cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16}),
    .unlocked  (unlocked),
    .ist       (ist_q),
    .imask     (mask_q)
);

// File: tb/nand_regbank_test.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected data, a monitor compares.
module nand_regbank_test;
    logic        clk = 0, rst_n = 0;
    logic [4:0]  bus_addr = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [3:0]  bus_be = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [5:0]  evt_pulse = 0;
    logic [6:0]  st_live = 0;
    logic        irq, cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16, ce_normal;
    logic [1:0]  tim_ce_dly;
    logic [4:0]  tim_busy;
    logic [2:0]  tim_ta;
    logic [3:0]  tim_rd_hi, tim_rd_lo, tim_wr_hi, tim_wr_lo;

    int checks = 0, errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 0;

    always #10 clk = ~clk;

    nand_regbank uut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d, logic [3:0] be);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1;
        @(posedge clk); #1;
        bus_wr = 0; bus_be = 0;
    endtask

    task automatic rd(logic [4:0] a, logic [31:0] exp, string tag, logic [5:0] ev = 0);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1; evt_pulse = ev;
        @(posedge clk); #1;
        bus_rd = 0; evt_pulse = 0;
    endtask

    task automatic pulse(logic [5:0] ev);
        evt_pulse = ev;
        @(posedge clk); #1;
        evt_pulse = 0;
    endtask

    // Monitor: compare read data mid-cycle against the queue
    always @(negedge clk) begin
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                errors++; $display("FAIL monitor: unexpected read");
            end else begin
                string t;
                logic [31:0] e;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;
        // R1 / R11: reset state
        check("R1 cfg", {cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16}, 0);
        check("R1 irq", irq, 0);
        check("R11 ce_normal reset", ce_normal, 1);
        rd(5'h0C, 0, "R1 status reset");
        rd(5'h14, 1, "R1 cem reset");
        rd(5'h02, 0, "R1 misaligned reads zero");
        // R4: locked write ignored, violation flag
        wr(5'h00, 32'hF, 4'hF);
        check("R4 cfg unchanged", {cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16}, 0);
        rd(5'h10, 32'h80, "R4 violation bit");
        // R2 / R5: unlock and write setup
        wr(5'h1C, 32'hA25E, 4'b0011);
        wr(5'h00, 32'h5, 4'hF);
        check("R5 cfg bits", {cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16}, 4'b0101);
        // R3: relocked
        wr(5'h00, 32'hF, 4'hF);
        check("R3 second write ignored", {cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16}, 4'b0101);
        // R6: timing fields
        wr(5'h1C, 32'hA25E, 4'b0011);
        wr(5'h04, 32'h03FF_FFFF, 4'hF);
        check("R6 fields", {tim_ce_dly, tim_busy, tim_ta, tim_rd_hi, tim_rd_lo, tim_wr_hi, tim_wr_lo},
              {2'd3, 5'h1F, 3'd7, 4'hF, 4'hF, 4'hF, 4'hF});
        // R2: byte-enable merge
        wr(5'h1C, 32'hA25E, 4'b0011);
        wr(5'h04, 32'h0, 4'b0001);
        check("R2 byte merge lo", {tim_wr_hi, tim_wr_lo}, 8'h00);
        check("R2 byte merge rd_lo kept", tim_rd_lo, 4'hF);
        // R2: wrong key keeps lock closed
        wr(5'h1C, 32'h1234, 4'b0011);
        wr(5'h00, 32'h0, 4'hF);
        check("R2 wrong key", {cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16}, 4'b0101);
        // R7 / R9: events, mask, irq
        wr(5'h08, 32'h20, 4'h1);
        pulse(6'h02);
        check("R9 masked event no irq", irq, 0);
        rd(5'h0C, 32'h02, "R7 ecc ready latched");
        rd(5'h0C, 32'h00, "R8 cleared after read");
        pulse(6'h20);
        check("R9 irq asserted", irq, 1);
        rd(5'h0C, 32'h20, "R8 read with event", 6'h20);
        check("R8 event wins irq", irq, 1);
        rd(5'h0C, 32'h20, "R8 bit kept");
        check("R9 irq drops after clear", irq, 0);
        // R12: live status
        st_live = 7'h5A;
        rd(5'h10, 32'hDA, "R12 live status");
        // R11: chip enable forced
        wr(5'h14, 32'h0, 4'h1);
        check("R11 ce forced", ce_normal, 0);
        rd(5'h14, 0, "R11 cem readback");
        // R10: commands
        wr(5'h18, 32'h12, 4'h1);
        check("R10 other cmd no effect", {cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16, ce_normal}, 5'b01010);
        pulse(6'h20);
        wr(5'h1C, 32'hA25E, 4'b0011);
        wr(5'h18, 32'hFF, 4'h1);
        check("R10 reset cfg/ce/irq", {cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16, ce_normal, irq}, 6'b000010);
        check("R10 reset timing", {tim_ce_dly, tim_busy, tim_ta, tim_rd_hi, tim_rd_lo}, 0);
        rd(5'h10, 32'h5A, "R10 violation cleared");
        rd(5'h08, 0, "R10 mask cleared");
        wr(5'h00, 32'hF, 4'hF);
        check("R10 relocked", {cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16}, 0);
        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            errors++; $display("FAIL monitor: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule